// File: doc/BRIEF.md
# Clock-Stop and Wake Controller

This block sequences the low-power clock-stop mode of a small microcontroller core. When the CPU executes its stop instruction it raises a one-cycle strobe. The controller then takes the core out of execution, turns off the oscillator and PLL enables, and forces the pad outputs into safe levels: display segment drivers and push-pull port outputs are held low, and open-drain outputs are released to high impedance.

While stopped, the controller watches two kinds of wake event. The first is a change on a port pin that is eligible for wake, set as an input and enabled as a break pin. Each pin is compared against the value captured on the cycle of the stop strobe. The second is the supply-present flag rising while its break enable is set. A wake moves the controller into standby. In standby the oscillator and PLL run again but the CPU stays held, and a fixed count of slow timer ticks (about 100 ms) must pass. Any further wake event during standby restarts that count. When the count expires the CPU enable returns and execution continues at the next address.

Top module: `clkstop_wake_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in run: `osc_en`, `pll_en` and `cpu_en` are 1, and `seg_force_low`, `pp_force_low` and `od_force_off` are 0.
- R2: In run, `pll_en` is 0 in the same cycle that `stop_req` is 1. From the next cycle on, `osc_en`, `pll_en` and `cpu_en` are all 0 (stopped).
- R3: `seg_force_low`, `pp_force_low` and `od_force_off` are 1 in every cycle in which the controller is stopped or in standby, and 0 in run.
- R4: While stopped, a change of `pin_in[i]` wakes the controller only if `pin_brk_en[i]`=1, `pin_is_in[i]`=1 (1 means input) and bit i of parameter `WAKE_MASK` is 1. Any other pin change leaves it stopped.
- R5: While stopped, a 0-to-1 transition of `supply_ok` wakes the controller only if `supply_brk_en`=1.
- R6: In standby, `osc_en`=1, `pll_en`=1 and `cpu_en`=0. The controller returns to run on the cycle after the `STBY_TICKS`-th sampled `tick` that has no wake event in the same cycle.
- R7: A wake event in standby restarts the tick count from zero. This holds even in the cycle where a tick would otherwise complete the count.
- R8: `stop_req` has no effect while stopped or in standby, and wake events have no effect in run.
- R9: The pin reference is the value sampled on the stop-strobe cycle and is updated every cycle after that. A pin that already differed before the stop strobe does not cause a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | One-cycle stop-instruction strobe |
| pin_in | input | NPORT | Port input levels |
| pin_brk_en | input | NPORT | Per-pin break enable |
| pin_is_in | input | NPORT | Per-pin direction, 1 = input |
| supply_ok | input | 1 | Supply-present flag |
| supply_brk_en | input | 1 | Supply-return wake enable |
| tick | input | 1 | Slow timer tick for the standby count |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_en | output | 1 | CPU execution enable |
| seg_force_low | output | 1 | Force display segment outputs low |
| pp_force_low | output | 1 | Force push-pull port outputs low |
| od_force_off | output | 1 | Force open-drain outputs off |

## Verification
The bench targets the pin qualification cases, where the design must reject each condition on its own:
- a change on a pin outside the mask;
- a change on a pin set as an output;
- a pin that already differed before the stop strobe.

A design that merges these conditions wrongly wakes early. A design that compares against a stale reference either never wakes or wakes on every cycle. The bench also checks that the PLL enable drops in the cycle of the strobe itself, since a registered-only decode would leave it high for one cycle too long. It lets a wake arrive partway through standby so that a design which fails to restart releases the CPU after too few ticks. Finally, it raises the supply both with and without its enable, so that a design which ignores the enable wakes when it must not.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_STOP = 2'd1,
    PM_STBY = 2'd2
  } pm_state_t;

  // Pins that may wake: changed vs reference, break-enabled, input, eligible.
  function automatic logic [63:0] wake_pins(input logic [63:0] cur,
                                            input logic [63:0] ref_v,
                                            input logic [63:0] brk,
                                            input logic [63:0] is_in,
                                            input logic [63:0] mask);
    return (cur ^ ref_v) & brk & is_in & mask;
  endfunction

  function automatic logic supply_rise(input logic now_v, input logic prev_v,
                                       input logic en);
    return now_v & ~prev_v & en;
  endfunction

endpackage

// File: rtl/clkstop_wake_det.sv
module clkstop_wake_det #(
  parameter int NPORT = 8,
  parameter logic [NPORT-1:0] WAKE_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             capture,
  input  logic [NPORT-1:0] pin_in,
  input  logic [NPORT-1:0] pin_brk_en,
  input  logic [NPORT-1:0] pin_is_in,
  input  logic             supply_ok,
  input  logic             supply_brk_en,
  output logic             pin_wake,
  output logic             sup_wake
);
  import clkstop_pkg::*;

  logic [NPORT-1:0] pin_ref;
  logic             sup_prev;
  logic [63:0]      hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_ref  <= '0;
      sup_prev <= 1'b1;
    end else begin
      if (armed || capture) pin_ref <= pin_in;
      sup_prev <= supply_ok;
    end
  end

  assign hits = wake_pins(64'(pin_in), 64'(pin_ref), 64'(pin_brk_en),
                          64'(pin_is_in), 64'(WAKE_MASK));
  assign pin_wake = armed && (hits != 64'd0);
  assign sup_wake = armed && supply_rise(supply_ok, sup_prev, supply_brk_en);

endmodule

// File: rtl/clkstop_stby_timer.sv
module clkstop_stby_timer #(
  parameter int STBY_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic restart,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(STBY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STBY_TICKS - 1);

  logic [CW-1:0] cnt;

  assign done = active && tick && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active || restart) cnt <= '0;
    else if (tick) cnt <= done ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stop_req,
  input  logic                   wake,
  input  logic                   stby_done,
  output clkstop_pkg::pm_state_t state
);
  import clkstop_pkg::*;

  pm_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN:  if (stop_req)  nxt = PM_STOP;
      PM_STOP: if (wake)      nxt = PM_STBY;
      PM_STBY: if (stby_done) nxt = PM_RUN;
      default: nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PM_RUN;
    else     state <= nxt;
  end

endmodule

// File: rtl/clkstop_wake_ctrl.sv
module clkstop_wake_ctrl #(
  parameter int NPORT = 8,
  parameter int STBY_TICKS = 100,
  parameter logic [NPORT-1:0] WAKE_MASK = 8'hD8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic [NPORT-1:0] pin_in,
  input  logic [NPORT-1:0] pin_brk_en,
  input  logic [NPORT-1:0] pin_is_in,
  input  logic             supply_ok,
  input  logic             supply_brk_en,
  input  logic             tick,
  output logic             osc_en,
  output logic             pll_en,
  output logic             cpu_en,
  output logic             seg_force_low,
  output logic             pp_force_low,
  output logic             od_force_off
);
  import clkstop_pkg::*;

  pm_state_t state;
  logic in_run, in_stop, in_stby;
  logic stop_take, pin_wake, sup_wake, wake_any, stby_done;

  assign in_run    = (state == PM_RUN);
  assign in_stop   = (state == PM_STOP);
  assign in_stby   = (state == PM_STBY);
  assign stop_take = in_run && stop_req;
  assign wake_any  = pin_wake || sup_wake;

  clkstop_wake_det #(.NPORT(NPORT), .WAKE_MASK(WAKE_MASK)) u_det (
    .clk(clk), .rst(rst), .armed(!in_run), .capture(stop_take),
    .pin_in(pin_in), .pin_brk_en(pin_brk_en), .pin_is_in(pin_is_in),
    .supply_ok(supply_ok), .supply_brk_en(supply_brk_en),
    .pin_wake(pin_wake), .sup_wake(sup_wake)
  );

  clkstop_stby_timer #(.STBY_TICKS(STBY_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .active(in_stby), .restart(wake_any),
    .tick(tick), .done(stby_done)
  );

  clkstop_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake(wake_any),
    .stby_done(stby_done), .state(state)
  );

  assign osc_en        = !in_stop;
  assign pll_en        = in_stby || (in_run && !stop_req);
  assign cpu_en        = in_run;
  assign seg_force_low = !in_run;
  assign pp_force_low  = !in_run;
  assign od_force_off  = !in_run;

endmodule

// File: rtl/clkstop_wake_ctrl_chk.sv
module clkstop_wake_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic stop_req,
  input logic tick,
  input logic osc_en,
  input logic pll_en,
  input logic cpu_en,
  input logic seg_force_low,
  input logic pp_force_low,
  input logic od_force_off,
  input logic pin_wake,
  input logic sup_wake
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cpu_en && osc_en && !seg_force_low && !pp_force_low && !od_force_off)); // R1

  AST_PLL_DROP: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && stop_req) |-> !pll_en); // R2

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && stop_req) |=> (!osc_en && !pll_en && !cpu_en)); // R2

  AST_OVERRIDE_HELD: assert property (@(posedge clk) disable iff (rst)
    !cpu_en |-> (seg_force_low && pp_force_low && od_force_off)); // R3

  AST_STAY_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && !pin_wake && !sup_wake) |=> !osc_en); // R4

  AST_STBY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (osc_en && !cpu_en && !tick) |=> !cpu_en); // R6

  AST_WAKE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (osc_en && !cpu_en && (pin_wake || sup_wake)) |=> !cpu_en); // R7

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && !stop_req) |=> cpu_en); // R8

endmodule

bind clkstop_wake_ctrl clkstop_wake_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .stop_req(stop_req), .tick(tick),
  .osc_en(osc_en), .pll_en(pll_en), .cpu_en(cpu_en),
  .seg_force_low(seg_force_low), .pp_force_low(pp_force_low),
  .od_force_off(od_force_off), .pin_wake(pin_wake), .sup_wake(sup_wake)
);

// File: tb/sim_clkstop_wake_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_wake_ctrl;
  localparam int TICKS = 4;
  localparam logic [7:0] MASK = 8'hD8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 1'b0;
  logic [7:0] pin_in = 8'h00, pin_brk_en = 8'h00, pin_is_in = 8'h00;
  logic supply_ok = 1'b1, supply_brk_en = 1'b0, tick = 1'b0;
  logic osc_en, pll_en, cpu_en, seg_force_low, pp_force_low, od_force_off;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  clkstop_wake_ctrl #(.NPORT(8), .STBY_TICKS(TICKS), .WAKE_MASK(MASK)) u0 (
    .clk(clk), .rst(rst), .stop_req(stop_req), .pin_in(pin_in),
    .pin_brk_en(pin_brk_en), .pin_is_in(pin_is_in), .supply_ok(supply_ok),
    .supply_brk_en(supply_brk_en), .tick(tick), .osc_en(osc_en),
    .pll_en(pll_en), .cpu_en(cpu_en), .seg_force_low(seg_force_low),
    .pp_force_low(pp_force_low), .od_force_off(od_force_off)
  );

  // Behavioural reference: 0 = run, 1 = stopped, 2 = standby.
  int m_st = 0;
  int m_cnt = 0;
  logic [7:0] m_ref = 8'h00;
  logic m_sup_prev = 1'b1;

  always @(posedge clk) begin
    bit w;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_sup_prev = 1'b1;
    end else begin
      w = 1'b0;
      if (m_st != 0) begin
        for (int i = 0; i < 8; i++)
          if (pin_in[i] != m_ref[i] && pin_brk_en[i] && pin_is_in[i] && MASK[i]) w = 1'b1;
        if (supply_ok && !m_sup_prev && supply_brk_en) w = 1'b1;
      end
      if (m_st != 0 || stop_req) m_ref = pin_in;
      m_sup_prev = supply_ok;
      if (m_st == 0) begin
        if (stop_req) m_st = 1;
      end else if (m_st == 1) begin
        if (w) begin m_st = 2; m_cnt = 0; end
      end else begin
        if (w) m_cnt = 0;
        else if (tick) begin
          m_cnt = m_cnt + 1;
          if (m_cnt == TICKS) begin m_st = 0; m_cnt = 0; end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    int e_osc, e_pll, e_cpu, e_ovr;
    e_osc = (m_st != 1);
    e_pll = (m_st == 2) || (m_st == 0 && !stop_req);
    e_cpu = (m_st == 0);
    e_ovr = (m_st != 0);
    chk(osc_en == e_osc, "R6 model osc_en", osc_en, e_osc);
    chk(pll_en == e_pll, "R2 model pll_en", pll_en, e_pll);
    chk(cpu_en == e_cpu, "R6 model cpu_en", cpu_en, e_cpu);
    chk({seg_force_low, pp_force_low, od_force_off} == {3{e_ovr[0]}},
        "R3 model overrides", {seg_force_low, pp_force_low, od_force_off}, {3{e_ovr[0]}});
  endtask

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (!rst) model_cmp();
      stop_req = 1'b0;
      tick = 1'b0;
    end
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin tick = 1'b1; cyc(); end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc();
    chk(osc_en && pll_en && cpu_en, "R1 enables after reset", {osc_en, pll_en, cpu_en}, 7);
    chk(!seg_force_low && !pp_force_low && !od_force_off, "R1 no overrides after reset",
        {seg_force_low, pp_force_low, od_force_off}, 0);

    // R8: wake-like events in run are ignored
    pin_brk_en = 8'hFF; pin_is_in = 8'hFF; supply_brk_en = 1'b1;
    pin_in = 8'h18; cyc(); supply_ok = 1'b0; cyc(); supply_ok = 1'b1; cyc();
    chk(cpu_en == 1, "R8 run ignores wake", cpu_en, 1);
    supply_brk_en = 1'b0;

    // R9: pin 4 already high before stop; reference taken at strobe
    pin_in = 8'h10;
    pin_is_in = 8'hF7;                // pin 3 configured as output
    cyc();
    stop_req = 1'b1;
    #1 chk(pll_en == 0, "R2 pll_en low on strobe cycle", pll_en, 0);
    cyc();
    chk(!osc_en && !pll_en && !cpu_en, "R2 stopped enables", {osc_en, pll_en, cpu_en}, 0);
    chk(seg_force_low && pp_force_low && od_force_off, "R3 overrides while stopped",
        {seg_force_low, pp_force_low, od_force_off}, 7);
    cyc(3);
    chk(osc_en == 0, "R9 pre-stop level does not wake", osc_en, 0);

    // R4: ineligible pin 0, output-configured pin 3
    pin_in = 8'h11; cyc(2);
    chk(osc_en == 0, "R4 masked pin ignored", osc_en, 0);
    pin_in = 8'h19; cyc(2);
    chk(osc_en == 0, "R4 output pin ignored", osc_en, 0);
    stop_req = 1'b1; cyc();
    chk(osc_en == 0 && cpu_en == 0, "R8 stop while stopped ignored", osc_en, 0);

    // R4: eligible input pin 6 wakes
    pin_in = 8'h59; cyc();
    chk(osc_en == 1 && pll_en == 1 && cpu_en == 0, "R4 pin wake into standby",
        {osc_en, pll_en, cpu_en}, 6);

    // R7: restart after 3 ticks, then full count needed
    tick_n(TICKS - 1);
    pin_in = 8'h19; tick = 1'b1; cyc();
    chk(cpu_en == 0, "R7 wake on tick restarts", cpu_en, 0);
    tick_n(TICKS - 1);
    chk(cpu_en == 0, "R7 still holding after restart", cpu_en, 0);
    cyc(2);
    chk(cpu_en == 0, "R6 no release without tick", cpu_en, 0);
    tick_n(1);
    chk(cpu_en == 1 && !seg_force_low, "R6 release after full count", cpu_en, 1);

    // R5: supply return
    stop_req = 1'b1; cyc();
    supply_ok = 1'b0; cyc(); supply_ok = 1'b1; cyc(2);
    chk(osc_en == 0, "R5 supply return without enable ignored", osc_en, 0);
    supply_brk_en = 1'b1;
    supply_ok = 1'b0; cyc();
    chk(osc_en == 0, "R5 supply fall does not wake", osc_en, 0);
    supply_ok = 1'b1; cyc();
    chk(osc_en == 1 && cpu_en == 0, "R5 supply return wakes", {osc_en, cpu_en}, 2);
    tick_n(TICKS);
    chk(cpu_en == 1, "R6 release after supply wake", cpu_en, 1);
    cyc(2);

    // R1: reset from standby
    stop_req = 1'b1; cyc();
    pin_in = 8'h99; cyc();
    rst = 1'b1; cyc(); rst = 1'b0; cyc();
    chk(cpu_en && osc_en && !od_force_off, "R1 reset from standby", cpu_en, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule